// File: doc/BRIEF.md
# ALU Status Word Flag Unit

This block holds the eight-bit status word of a small accumulator-based processor core. Each time the core finishes an arithmetic operation (add, add with carry, subtract with borrow, multiply or divide), it presents a one-cycle strobe, the operation code and both operands. On the next clock edge the unit records the carry, half carry and overflow flags for that result. Add with carry and subtract with borrow take the stored carry as their incoming carry or borrow.

Software changes the word in two ways: a whole-byte write, or a write that sets or clears a single bit chosen by index. The lowest bit is never stored. It is the parity of the accumulator, computed on every cycle from the accumulator value the core supplies, and writes to it have no effect. A two-bit bank select field chooses one of four groups of eight working registers. The unit drives the base address of the selected group so the register file can add it to the register number.

Top module: `psw_flag_unit`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, and after it is released, every stored bit of `statusWord` is 0 and `bankBase` is 0.
- R2: The `statusWord` bit positions are: 7 carry, 6 half carry (carry or borrow between the low and high nibble), 5 user flag A, 4:3 bank select, 2 overflow, 1 user flag B, 0 parity.
- R3: For add (`opSel`=0) and add with carry (`opSel`=1, incoming carry = stored carry), carry takes the carry out of bit 7 and half carry takes the carry out of bit 3, one cycle after the `opValid` strobe.
- R4: For subtract with borrow (`opSel`=2, incoming borrow = stored carry), carry takes the borrow out of bit 7 of A−B−borrow and half carry takes the borrow out of the low nibble.
- R5: For operation codes 0, 1 and 2, overflow is 1 exactly when the two's-complement result falls outside −128..127.
- R6: For multiply (`opSel`=3), overflow is 1 exactly when A×B exceeds 255, and carry and half carry become 0.
- R7: For divide (`opSel`=4), overflow is 1 exactly when B is 0, and carry and half carry become 0.
- R8: `statusWord[0]` is 1 when `accValue` holds an odd number of ones, in the same cycle, and a byte or bit write to bit 0 has no effect on it.
- R9: `bankBase` equals the bank select field times 8, that is 0, 8, 16 or 24.
- R10: A byte write loads bits 7:1 from `byteWrData`. A bit write loads `bitWrVal` into the bit at `bitWrIdx`. When both target the same bit in one cycle, the bit write wins.
- R11: When an arithmetic strobe and a software write fall in the same cycle, carry, half carry and overflow take the arithmetic result, and the written user flags and bank select still take effect.
- R12: With `opValid` low, or with `opSel` 5 to 7, and no write, all stored bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Arithmetic result strobe |
| opSel | input | 3 | Operation: 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide |
| opA | input | 8 | First operand (accumulator side) |
| opB | input | 8 | Second operand / divisor |
| accValue | input | 8 | Current accumulator contents |
| byteWrEn | input | 1 | Whole-word software write |
| byteWrData | input | 8 | Data for the whole-word write |
| bitWrEn | input | 1 | Single-bit software write |
| bitWrIdx | input | 3 | Bit index for the single-bit write |
| bitWrVal | input | 1 | Value for the single-bit write |
| statusWord | output | 8 | Status word with live parity in bit 0 |
| bankBase | output | 5 | Base address of the selected register group |

## Verification
Additions are run with operands that produce a carry only from the low nibble, only from the high byte, a sign flip without carry, and both at once. These cases separate half carry from carry and both from overflow. Subtractions are run with a stored carry of 1 and of 0, which shows that the borrow input is used. Products of exactly 255 and 256, and divisors of zero and non-zero, test the two boundaries of overflow. Pseudo-random operand pairs fed through all five operations check the flags against an integer model of signed and unsigned results. Writes that collide with strobes, or with each other, expose the priority order.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } aluOp_e;

  localparam int WORD_W    = 8;
  localparam int CARRY_BIT = 7;
  localparam int HALF_BIT  = 6;
  localparam int OVF_BIT   = 2;
  localparam int PAR_BIT   = 0;
  localparam int BANK_LO   = 3;
  localparam int BANK_HI   = 4;

  // bits owned by the arithmetic path when a strobe is present
  localparam logic [WORD_W-1:0] ARITH_MASK = 8'b1100_0100;

  typedef struct packed {
    logic              arithEn;
    aluOp_e            op;
    logic [WORD_W-1:0] wrMask;
    logic [WORD_W-1:0] wrData;
  } flagCtrl_t;

endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic              byteWrEn,
  input  logic [WORD_W-1:0] byteWrData,
  input  logic              bitWrEn,
  input  logic [2:0]        bitWrIdx,
  input  logic              bitWrVal,
  output flagCtrl_t         ctrl
);

  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] data;
  logic              known;

  assign known = (opSel <= 3'd4);

  always_comb begin
    mask = '0;
    data = '0;
    if (byteWrEn) begin
      mask = {WORD_W{1'b1}};
      data = byteWrData;
    end
    // single-bit write overrides the byte write on its own bit
    if (bitWrEn) begin
      mask[bitWrIdx] = 1'b1;
      data[bitWrIdx] = bitWrVal;
    end
    mask[PAR_BIT] = 1'b0;
    if (opValid && known) mask = mask & ~ARITH_MASK;
  end

  always_comb begin
    ctrl.arithEn = opValid && known;
    ctrl.op      = known ? aluOp_e'(opSel) : OP_ADD;
    ctrl.wrMask  = mask;
    ctrl.wrData  = data;
  end

endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int BANK_REGS = 8,
  localparam int BANK_SHIFT = $clog2(BANK_REGS),
  localparam int BASE_W = 2 + BANK_SHIFT
)(
  input  logic              clk,
  input  logic              rstN,
  input  flagCtrl_t         ctrl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] accValue,
  output logic [WORD_W-1:0] statusWord,
  output logic [BASE_W-1:0] bankBase
);

  logic [WORD_W-1:1] flagReg;
  logic              carryIn;
  logic [WORD_W:0]   addSum;
  logic [4:0]        addNib;
  logic [WORD_W:0]   subDiff;
  logic [4:0]        subNib;
  logic [2*WORD_W-1:0] product;
  logic [WORD_W-1:0] arithVal;

  assign carryIn = (ctrl.op == OP_ADD) ? 1'b0 : flagReg[CARRY_BIT];
  assign addSum  = {1'b0, opA} + {1'b0, opB} + {{WORD_W{1'b0}}, carryIn};
  assign addNib  = {1'b0, opA[3:0]} + {1'b0, opB[3:0]} + {4'd0, carryIn};
  assign subDiff = {1'b0, opA} - {1'b0, opB} - {{WORD_W{1'b0}}, carryIn};
  assign subNib  = {1'b0, opA[3:0]} - {1'b0, opB[3:0]} - {4'd0, carryIn};
  assign product = opA * opB;

  always_comb begin
    arithVal = '0;
    unique case (ctrl.op)
      OP_ADD, OP_ADDC: begin
        arithVal[CARRY_BIT] = addSum[WORD_W];
        arithVal[HALF_BIT]  = addNib[4];
        arithVal[OVF_BIT]   = (opA[7] == opB[7]) && (addSum[7] != opA[7]);
      end
      OP_SUBB: begin
        arithVal[CARRY_BIT] = subDiff[WORD_W];
        arithVal[HALF_BIT]  = subNib[4];
        arithVal[OVF_BIT]   = (opA[7] != opB[7]) && (subDiff[7] != opA[7]);
      end
      OP_MUL:  arithVal[OVF_BIT] = |product[2*WORD_W-1:WORD_W];
      OP_DIV:  arithVal[OVF_BIT] = (opB == '0);
      default: arithVal = '0;
    endcase
  end

  for (genvar i = 1; i < WORD_W; i++) begin : g_flag
    if (ARITH_MASK[i]) begin : g_arith
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                flagReg[i] <= 1'b0;
        else if (ctrl.arithEn)    flagReg[i] <= arithVal[i];
        else if (ctrl.wrMask[i])  flagReg[i] <= ctrl.wrData[i];
      end
    end else begin : g_soft
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                flagReg[i] <= 1'b0;
        else if (ctrl.wrMask[i])  flagReg[i] <= ctrl.wrData[i];
      end
    end
  end

  assign statusWord = {flagReg, ^accValue};
  assign bankBase   = {flagReg[BANK_HI:BANK_LO], {BANK_SHIFT{1'b0}}};

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int BANK_REGS = 8,
  localparam int BASE_W = 2 + $clog2(BANK_REGS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] accValue,
  input  logic              byteWrEn,
  input  logic [WORD_W-1:0] byteWrData,
  input  logic              bitWrEn,
  input  logic [2:0]        bitWrIdx,
  input  logic              bitWrVal,
  output logic [WORD_W-1:0] statusWord,
  output logic [BASE_W-1:0] bankBase
);

  flagCtrl_t ctrl;

  psw_ctrl u_ctrl (
    .opValid    (opValid),
    .opSel      (opSel),
    .byteWrEn   (byteWrEn),
    .byteWrData (byteWrData),
    .bitWrEn    (bitWrEn),
    .bitWrIdx   (bitWrIdx),
    .bitWrVal   (bitWrVal),
    .ctrl       (ctrl)
  );

  psw_datapath #(.BANK_REGS(BANK_REGS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .accValue   (accValue),
    .statusWord (statusWord),
    .bankBase   (bankBase)
  );

endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter int BASE_W = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic [7:0]        opB,
  input logic [7:0]        accValue,
  input logic              byteWrEn,
  input logic [7:0]        byteWrData,
  input logic              bitWrEn,
  input logic [7:0]        statusWord,
  input logic [BASE_W-1:0] bankBase
);

  // R8: accumulator plus parity bit always hold an even count of ones
  assert_parity_even_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({accValue, statusWord[0]}) % 2) == 0);

  // R9: base address follows the bank field
  assert_bank_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    int'(bankBase) == int'(statusWord[4:3]) * 8);

  // R6: multiply leaves carry clear
  assert_mul_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd3) |=> !statusWord[7]);

  // R7: zero divisor raises overflow
  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd4 && opB == 8'd0) |=> statusWord[2]);

  // R7: non-zero divisor clears overflow
  assert_div_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd4 && opB != 8'd0) |=> !statusWord[2]);

  // R12: quiet cycle keeps stored bits
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!(opValid && opSel <= 3'd4) && !byteWrEn && !bitWrEn) |=> $stable(statusWord[7:1]));

  // R10: lone byte write loads user flag A
  assert_byte_user_R10: assert property (@(posedge clk) disable iff (!rstN)
    (byteWrEn && !bitWrEn) |=> statusWord[5] == $past(byteWrData[5]));

endmodule

bind psw_flag_unit psw_checker #(.BASE_W(BASE_W)) u_chk (.*);

// File: tb/sim_psw_flag_unit.sv
`timescale 1ns/1ps
module sim_psw_flag_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opSel = '0;
  logic [7:0] opA = '0, opB = '0, accValue = '0;
  logic       byteWrEn = 1'b0;
  logic [7:0] byteWrData = '0;
  logic       bitWrEn = 1'b0;
  logic [2:0] bitWrIdx = '0;
  logic       bitWrVal = 1'b0;
  logic [7:0] statusWord;
  logic [4:0] bankBase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit mC, mH, mA, mO, mB;
  int mBank;

  always #4 clk = ~clk;  // 125 MHz

  psw_flag_unit u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int expWord(input int acc);
    int ones = 0;
    for (int k = 0; k < 8; k++) ones += (acc >> k) & 1;
    return (int'(mC) << 7) | (int'(mH) << 6) | (int'(mA) << 5) | (mBank << 3)
         | (int'(mO) << 2) | (int'(mB) << 1) | (ones % 2);
  endfunction

  task automatic step(input string tag, input bit v, input int op, input int a, input int b,
                      input int acc, input bit bw, input int bd,
                      input bit tw, input int ti, input bit tv);
    bit arith;
    int cin, r, sr, w;
    bit nC, nH, nO;
    @(negedge clk);
    opValid = v; opSel = op[2:0]; opA = a[7:0]; opB = b[7:0]; accValue = acc[7:0];
    byteWrEn = bw; byteWrData = bd[7:0]; bitWrEn = tw; bitWrIdx = ti[2:0]; bitWrVal = tv;
    @(posedge clk);
    arith = v && op <= 4;
    cin = (op == 1 || op == 2) ? int'(mC) : 0;
    nC = 0; nH = 0; nO = 0;
    if (op == 0 || op == 1) begin
      r = a + b + cin; nC = r > 255; nH = (a % 16 + b % 16 + cin) > 15;
      sr = toSigned(a) + toSigned(b) + cin; nO = sr > 127 || sr < -128;
    end else if (op == 2) begin
      r = a - b - cin; nC = r < 0; nH = (a % 16 - b % 16 - cin) < 0;
      sr = toSigned(a) - toSigned(b) - cin; nO = sr > 127 || sr < -128;
    end else if (op == 3) nO = (a * b) > 255;
    else if (op == 4) nO = (b == 0);
    w = (int'(mC) << 7) | (int'(mH) << 6) | (int'(mA) << 5) | (mBank << 3) | (int'(mO) << 2) | (int'(mB) << 1);
    if (bw) w = bd;
    if (tw) w = tv ? (w | (1 << ti)) : (w & ~(1 << ti));
    mC = w[7]; mH = w[6]; mA = w[5]; mBank = (w >> 3) & 3; mO = w[2]; mB = w[1];
    if (arith) begin mC = nC; mH = nH; mO = nO; end
    #1;
    check({tag, " word"}, statusWord, expWord(acc));
    check({tag, " bank"}, bankBase, mBank * 8);
  endtask

  task automatic arithOp(input string tag, input int op, input int a, input int b);
    step(tag, 1, op, a, b, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bitWr(input string tag, input int idx, input bit val);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, idx, val);
  endtask

  initial begin
    int seed = 32'h1234;
    // R1: reset state
    #2;
    check("R1 reset word", statusWord, 0);
    check("R1 reset bank", bankBase, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mC = 0; mH = 0; mA = 0; mO = 0; mB = 0; mBank = 0;
    step("R1 after release", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 / R2: carry and half carry positions
    arithOp("R3 add carry+half", 0, 'h3A, 'hC6);
    arithOp("R3 addc uses carry", 1, 'h0F, 'h00);
    arithOp("R3 add half only", 0, 'h08, 'h08);
    // R5 signed overflow
    arithOp("R5 add pos overflow", 0, 'h7F, 'h01);
    arithOp("R5 add neg overflow", 0, 'h80, 'h80);
    // R4 borrow with stored carry 1 then 0
    arithOp("R4 subb half borrow", 2, 'h10, 'h01);
    arithOp("R4 subb borrow", 2, 'h00, 'h01);
    arithOp("R5 subb overflow", 2, 'h80, 'h01);
    // R6 / R7 boundaries
    arithOp("R6 mul 256", 3, 'h10, 'h10);
    arithOp("R6 mul 255", 3, 'h0F, 'h11);
    arithOp("R7 div zero", 4, 'h0A, 'h00);
    arithOp("R7 div ok", 4, 'h0A, 'h03);
    // R10 byte write, R8 parity tracking and ignored write
    step("R10 byte write", 0, 0, 0, 0, 'h07, 1, 'hFF, 0, 0, 0);
    step("R8 parity odd acc", 0, 0, 0, 0, 'h01, 0, 0, 0, 0, 0);
    step("R8 write bit0 ignored", 0, 0, 0, 0, 'h00, 1, 'h01, 0, 0, 0);
    bitWr("R8 bitwrite bit0 ignored", 0, 1);
    for (int i = 1; i < 8; i++) bitWr("R10 bit set", i, 1);
    for (int i = 1; i < 8; i++) bitWr("R10 bit clear", i, 0);
    // R9 all banks
    for (int bk = 0; bk < 4; bk++) begin
      bitWr("R9 bank lo", 3, bk[0]);
      bitWr("R9 bank hi", 4, bk[1]);
    end
    // R10 bit write wins over byte write
    step("R10 bit beats byte", 0, 0, 0, 0, 0, 1, 'hFF, 1, 5, 0);
    // R11 arithmetic beats write on its bits
    step("R11 op beats write", 1, 0, 1, 1, 0, 1, 'hFF, 0, 0, 0);
    step("R11 op beats bit write", 1, 3, 2, 2, 0, 0, 0, 1, 7, 1);
    // R12 idle and unknown codes
    step("R12 idle", 0, 0, 'hFF, 'hFF, 'h03, 0, 0, 0, 0, 0);
    step("R12 opSel 5", 1, 5, 'hFF, 'hFF, 0, 0, 0, 0, 0, 0);
    step("R12 opSel 7", 1, 7, 'h80, 'h80, 0, 0, 0, 0, 0, 0);
    // R5 mixed operands across all operations
    for (int n = 0; n < 300; n++) begin
      seed = seed * 1103515245 + 12345;
      step("R5 sweep", 1, (seed >>> 8) & 32'h7 % 5 == 0 ? 0 : ((seed >>> 8) & 7) % 5,
           (seed >>> 12) & 255, (seed >>> 20) & 255, (seed >>> 4) & 255, 0, 0, 0, 0, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule